// File: doc/BRIEF.md
# Pixel-Clock Synthesizer Word Calculator

This block turns a requested pixel period, given in picoseconds, into the 13-bit program word for a clock synthesizer with a fixed reference. It can also reject the request with an error flag. It first finds the frequency in units of 0.01 MHz, using one sequential divider. If the frequency sits below the VCO band, it is doubled until it lies inside the band, and the number of doublings gives the post divider.

The scaled frequency is then turned into a feedback count. A sequential shift-add multiplier scales it up, and two more passes through the same divider apply the reference ratio and round to whole units. The final word packs three things: the count less a fixed offset, a two-bit post-divider field, and two stop bits that are always set.

A request is accepted by pulsing the start input while the block is idle. The result shows on the outputs in the cycle of a one-cycle done pulse, and it is held there until the next result. The slot address that goes with the word is always zero.

Top module: `pclk_word_calc`

## Requirements
- R1: The frequency is f = floor(100000000 / period_i). A request with f above 15938 or below 1000 finishes with err_o=1, word_o=0 and post_div_o=0. A request with f from 1000 to 15938 inclusive finishes with err_o=0.
- R2: A period of zero finishes with err_o=1 and does not hang.
- R3: While f is below 8000 it is doubled, and the post divider, which starts at 1, is doubled with it. post_div_o reports the final divider, one of 1, 2, 4 or 8.
- R4: The count is c = floor((floor(f*46000/1432) + 500) / 1000), using the scaled f. word_o[8:0] equals (c - 257) masked to 9 bits.
- R5: word_o[10:9] is 2'b11, 2'b10, 2'b01 or 2'b00 for a post divider of 1, 2, 4 or 8.
- R6: word_o[12:11] is 2'b11 on every successful result.
- R7: done_o is high for exactly one cycle per accepted request, with busy_o low in that cycle. word_o, err_o and post_div_o change only in a done cycle.
- R8: A start_i pulse while busy_o is high is ignored. It produces no extra done pulse and does not alter the result of the request in flight.
- R9: After reset, busy_o, done_o and err_o are 0, and word_o and post_div_o are 0.
- R10: loc_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; accepted only while idle |
| period_i | input | 32 | Requested pixel period in picoseconds, sampled at accept |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Last request was out of range or had a zero period |
| word_o | output | 13 | Synthesizer program word |
| post_div_o | output | 4 | Post divider of the last result (1, 2, 4, 8; 0 on error) |
| loc_o | output | 5 | Synthesizer slot address, always 0 |

## Verification
A wrong doubling count shows up at once in the done cycle, and in two ways. post_div_o is off by a power of two, and word_o[10:9] is off as well. Because the other branch of the loop scales f differently, the low count bits usually move too.

A divider or multiplier that keeps stale state, or that loses a bit, damages word_o[8:0] for whole ranges of periods. Checking every output against an independent arithmetic model in each done cycle exposes it. A handshake fault shows as a missing or doubled done pulse, or as outputs that drift between results, and this is seen within the same request.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int unsigned FREQ_NUM_D  = 100_000_000;
  localparam int unsigned F_MIN_D     = 1000;
  localparam int unsigned F_MAX_D     = 15938;
  localparam int unsigned F_VCO_D     = 8000;
  localparam int unsigned REF_NUM_D   = 46;
  localparam int unsigned REF_DEN_D   = 1432;
  localparam int unsigned SCALE_D     = 1000;
  localparam int unsigned N_OFS_D     = 257;
  localparam int unsigned STOP_BITS_D = 'h1800;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_SCALE,
    ST_MUL,
    ST_RATIO,
    ST_ROUND
  } calc_state_e;
endpackage

// File: rtl/pclk_seq_div.sv
module pclk_seq_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic         dz_o,
  output logic [W-1:0] quo_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          busy_q, done_q, dz_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [W:0]    trial;
  logic          fit;

  assign trial = {rem_q, quo_q[W-1]};
  assign fit   = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        dz_q  <= (den_i == '0);
        rem_q <= '0;
        den_q <= den_i;
        if (den_i == '0) begin
          // zero divisor: finish at once instead of iterating
          quo_q  <= '0;
          done_q <= 1'b1;
        end else begin
          quo_q  <= num_i;
          cnt_q  <= CW'(W);
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (fit) begin
          rem_q <= W'(trial - {1'b0, den_q});
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign dz_o   = dz_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/pclk_seq_mul.sv
module pclk_seq_mul #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] prod_o
);
  logic         busy_q, done_q;
  logic [W-1:0] acc_q, mcand_q, mplier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        acc_q    <= '0;
        mcand_q  <= a_i;
        mplier_q <= b_i;
        if (b_i == '0) done_q <= 1'b1;
        else           busy_q <= 1'b1;
      end else if (busy_q) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        // stop once no multiplier bits remain
        if ((mplier_q >> 1) == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/pclk_word_enc.sv
module pclk_word_enc #(
  parameter int unsigned WORD_W    = 13,
  parameter int unsigned FLD_LSB   = 9,
  parameter int unsigned KW        = 2,
  parameter int unsigned N_OFS     = 257,
  parameter int unsigned STOP_BITS = 'h1800
) (
  input  logic [WORD_W-1:0] count_i,
  input  logic [KW-1:0]     k_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [KW-1:0]     K_TOP    = '1;
  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'((1 << FLD_LSB) - 1);
  localparam logic [WORD_W-1:0] STOP_W   = WORD_W'(STOP_BITS);

  logic [WORD_W-1:0] diff, fld;

  always_comb begin
    diff   = count_i - WORD_W'(N_OFS);
    // field counts down as the post divider grows
    fld    = WORD_W'(K_TOP - k_i) << FLD_LSB;
    word_o = STOP_W | fld | (diff & LOW_MASK);
  end
endmodule

// File: rtl/pclk_word_calc.sv
module pclk_word_calc
  import pclk_pkg::*;
#(
  parameter int unsigned PW        = 32,
  parameter int unsigned WORD_W    = 13,
  parameter int unsigned FLD_LSB   = 9,
  parameter int unsigned KW        = 2,
  parameter int unsigned LOC_W     = 5,
  parameter int unsigned FREQ_NUM  = FREQ_NUM_D,
  parameter int unsigned F_MIN     = F_MIN_D,
  parameter int unsigned F_MAX     = F_MAX_D,
  parameter int unsigned F_VCO     = F_VCO_D,
  parameter int unsigned REF_NUM   = REF_NUM_D,
  parameter int unsigned REF_DEN   = REF_DEN_D,
  parameter int unsigned SCALE     = SCALE_D,
  parameter int unsigned N_OFS     = N_OFS_D,
  parameter int unsigned STOP_BITS = STOP_BITS_D
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [PW-1:0]         period_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic [WORD_W-1:0]     word_o,
  output logic [(2**KW)-1:0]    post_div_o,
  output logic [LOC_W-1:0]      loc_o
);
  localparam int unsigned PDW   = 2 ** KW;
  localparam int unsigned MUL_K = REF_NUM * SCALE;
  localparam int unsigned RND   = SCALE / 2;

  calc_state_e          state_q;
  logic [PW-1:0]        f_q;
  logic [KW-1:0]        k_q;
  logic [WORD_W-1:0]    word_q;
  logic [PDW-1:0]       pdiv_q;
  logic                 err_q, done_q;

  logic                 div_go, div_done, div_dz;
  logic [PW-1:0]        div_num, div_den, div_quo;
  logic                 mul_go, mul_done;
  logic [PW-1:0]        mul_prod;
  logic [WORD_W-1:0]    enc_word;
  logic                 f_bad;

  // one divider shared by the three quotient steps
  always_comb begin
    div_go  = 1'b0;
    div_num = PW'(FREQ_NUM);
    div_den = period_i;
    unique case (state_q)
      ST_IDLE:  div_go = start_i;
      ST_MUL: begin
        div_go  = mul_done;
        div_num = mul_prod;
        div_den = PW'(REF_DEN);
      end
      ST_RATIO: begin
        div_go  = div_done;
        div_num = div_quo + PW'(RND);
        div_den = PW'(SCALE);
      end
      default: ;
    endcase
  end

  assign mul_go = (state_q == ST_SCALE) && (f_q >= PW'(F_VCO));
  assign f_bad  = div_dz || (div_quo > PW'(F_MAX)) || (div_quo < PW'(F_MIN));

  pclk_seq_div #(.W(PW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .dz_o   (div_dz),
    .quo_o  (div_quo)
  );

  pclk_seq_mul #(.W(PW)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (mul_go),
    .a_i    (f_q),
    .b_i    (PW'(MUL_K)),
    .done_o (mul_done),
    .prod_o (mul_prod)
  );

  pclk_word_enc #(
    .WORD_W    (WORD_W),
    .FLD_LSB   (FLD_LSB),
    .KW        (KW),
    .N_OFS     (N_OFS),
    .STOP_BITS (STOP_BITS)
  ) u_enc (
    .count_i (div_quo[WORD_W-1:0]),
    .k_i     (k_q),
    .word_o  (enc_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      f_q     <= '0;
      k_q     <= '0;
      word_q  <= '0;
      pdiv_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_FREQ;
        ST_FREQ: if (div_done) begin
          if (f_bad) begin
            err_q   <= 1'b1;
            word_q  <= '0;
            pdiv_q  <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            f_q     <= div_quo;
            k_q     <= '0;
            state_q <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (f_q < PW'(F_VCO)) begin
            f_q <= f_q << 1;
            k_q <= k_q + 1'b1;
          end else begin
            state_q <= ST_MUL;
          end
        end
        ST_MUL:   if (mul_done) state_q <= ST_RATIO;
        ST_RATIO: if (div_done) state_q <= ST_ROUND;
        ST_ROUND: if (div_done) begin
          word_q  <= enc_word;
          pdiv_q  <= PDW'(1) << k_q;
          err_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign word_o     = word_q;
  assign post_div_o = pdiv_q;
  assign loc_o      = '0;
endmodule

// File: rtl/pclk_word_calc_chk.sv
module pclk_word_calc_chk #(
  parameter int unsigned WORD_W = 13,
  parameter int unsigned PDW    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [WORD_W-1:0] word_o,
  input logic [PDW-1:0]    post_div_o
);
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(word_o) && $stable(err_o) && $stable(post_div_o)));

  a_r8_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r1_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (word_o == '0 && post_div_o == '0));

  a_r6_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (word_o[12:11] == 2'b11));

  a_r3_pdiv_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ($countones(post_div_o) == 1));

  a_r5_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |->
      ((post_div_o == 4'd1 && word_o[10:9] == 2'b11) ||
       (post_div_o == 4'd2 && word_o[10:9] == 2'b10) ||
       (post_div_o == 4'd4 && word_o[10:9] == 2'b01) ||
       (post_div_o == 4'd8 && word_o[10:9] == 2'b00)));
endmodule

bind pclk_word_calc pclk_word_calc_chk #(.WORD_W(13), .PDW(4)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .word_o     (word_o),
  .post_div_o (post_div_o)
);

// File: tb/pclk_word_calc_tb.sv
module pclk_word_calc_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] period_i = '0;
  logic        busy_o, done_o, err_o;
  logic [12:0] word_o;
  logic [3:0]  post_div_o;
  logic [4:0]  loc_o;

  int checks = 0;
  int errs   = 0;

  always #5 clk = ~clk;

  pclk_word_calc u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .period_i   (period_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .word_o     (word_o),
    .post_div_o (post_div_o),
    .loc_o      (loc_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input longint p, output bit e, output int w, output int pd);
    longint f, c;
    int fld;
    e = 1'b0; w = 0; pd = 0;
    if (p == 0) begin e = 1'b1; return; end
    f = 100000000 / p;
    if (f > 15938 || f < 1000) begin e = 1'b1; return; end
    pd = 1;
    while (f < 8000) begin f = f * 2; pd = pd * 2; end
    c   = ((f * 46000) / 1432 + 500) / 1000;
    fld = (pd == 1) ? 3 : (pd == 2) ? 2 : (pd == 4) ? 1 : 0;
    w   = 'h1800 | (fld << 9) | int'((c - 257) & 'h1ff);
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_o) begin ok = 1'b1; break; end
    end
    if (!ok) chk(1'b0, "R7 timeout waiting for done", 0, 1);
  endtask

  task automatic compare(input longint p);
    bit e; int w, pd;
    model(p, e, w, pd);
    chk(err_o == e, (p == 0) ? "R2 err" : "R1 err", err_o, e);
    chk(loc_o == 0, "R10 loc", loc_o, 0);
    if (e) begin
      chk(word_o == 0 && post_div_o == 0, "R1 outputs on error", {post_div_o, word_o}, 0);
    end else begin
      chk(post_div_o == pd, "R3 post divider", post_div_o, pd);
      chk(word_o[8:0] == w[8:0], "R4 count field", word_o[8:0], w[8:0]);
      chk(word_o[10:9] == w[10:9], "R5 divider field", word_o[10:9], w[10:9]);
      chk(word_o[12:11] == 2'b11, "R6 stop bits", word_o[12:11], 3);
    end
  endtask

  task automatic run(input longint p);
    bit ok;
    @(negedge clk);
    period_i = 32'(p);
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    wait_done(ok);
    if (ok) compare(p);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    bit ok;
    int npulse;
    logic [12:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy_o && !done_o && !err_o, "R9 flags", {busy_o, done_o, err_o}, 0);
    chk(word_o == 0 && post_div_o == 0, "R9 data", {post_div_o, word_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // boundaries: zero, tiny, top edge, bottom edge, VCO edge, huge
    run(0);
    run(1);
    run(6273);
    run(6274);
    run(100000);
    run(100001);
    run(12500);
    run(12501);
    run(32'hFFFF_FFFF);
    for (longint p = 12480; p <= 12520; p++) run(p);
    for (longint p = 6000; p <= 101000; p += 173) run(p);

    // R8: start during busy is ignored
    @(negedge clk);
    period_i = 32'd12501;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    repeat (4) @(negedge clk);
    period_i = 32'd6273;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    period_i = 32'd12501;
    wait_done(ok);
    if (ok) compare(12501);
    // R7: single pulse, then outputs held
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", done_o, 0);
    held   = word_o;
    npulse = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done_o) npulse++;
    end
    chk(npulse == 0, "R8 no extra done", npulse, 0);
    chk(word_o == held && !busy_o, "R7 result held", word_o, held);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule